// File: doc/BRIEF.md
# USB Dual-Role Port Mode Selector

This block settles whether a dual-role USB port works as a host (A-device) or as a peripheral (B-device). By default it uses the ID level sensed by the PHY. A software override in the mode register can replace that level. The block passes the chosen ID level on to the controller and latches the role when a session begins. For a host session it drives the VBUS supply enable and watches VBUS-valid. If the supply does not come up in time, the block treats this as an over-current on the current-limited source and retries. When the retries are used up it raises an error. In peripheral role, software can turn on the D+ pull-up.

The block has three registers on a plain 32-bit write/read bus. A write takes effect at the clock edge where the write strobe is high. Read data is combinational from the address. The bus carries no stream, so it has no valid/ready handshake and no back-pressure. Every status and control pin is a plain level.

Top module: `usb_role_select`

## Requirements
- R1: After reset, every register reads 0 except the timeout register, which reads its reset value of 65535. `vbus_drive`, `vbus_err`, `retry_cnt` and `dp_pullup` are 0. One clock after reset ends, the role follows the sensed ID level.
- R2: While mode bit 7 is 0, `ctl_id` equals `phy_id`. Mode bit 8 then has no effect on `ctl_id` or on the role.
- R3: While mode bit 7 is 1, `ctl_id` equals mode bit 8. Writing 0x080 forces host and writing 0x180 forces peripheral, whatever `phy_id` is.
- R4: With no session active and VBUS-valid low, `role_dev` equals the effective ID one clock later: 0 selects host and 1 selects peripheral.
- R5: If VBUS-valid is high while no session is active, `role_dev` becomes 1 whatever the effective ID is. A session started in that state is a peripheral session.
- R6: While a session is active (power bit 0 set), `role_dev` holds its value. An override change takes effect one clock after the session ends.
- R7: In a host session, `vbus_drive` goes high one clock after the session starts. It stays high while VBUS-valid is high.
- R8: If VBUS-valid stays low for the programmed timeout count of cycles while the supply is driven, or VBUS-valid falls after it has risen, two things happen: `vbus_drive` drops for one cycle and `retry_cnt` increments. After a timeout with `retry_cnt` at 3, `vbus_err` latches high and the drive stays off.
- R9: `vbus_err` and `retry_cnt` clear when software writes power bit 0 as 1, or when the role changes. Ending a session does not clear them.
- R10: `dp_pullup` is high only when power bit 6 is set and the role is peripheral.
- R11: The register map is as follows. Mode at 0x0 holds bits 8 and 7. Power at 0x4 holds bit 6 (pull-up) and bit 0 (session). Timeout at 0x8 holds bits 15:0. Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| phy_id | input | 1 | ID level sensed by the PHY (0 = pin grounded) |
| phy_vbus_valid | input | 1 | VBUS above the valid threshold |
| ctl_id | output | 1 | Effective ID sent to the controller |
| role_dev | output | 1 | 1 = peripheral role, 0 = host role |
| vbus_drive | output | 1 | Enable for the VBUS power switch |
| vbus_err | output | 1 | Latched VBUS error, level |
| retry_cnt | output | 2 | Supply start retries used |
| dp_pullup | output | 1 | D+ pull-up enable |

## Verification
`ctl_id` is combinational, so it is due in the cycle after a mode write. `role_dev` is registered one stage behind the effective ID, and the bench always samples it two falling edges after the write. A host session raises `vbus_drive` one edge after the session write. The first timeout lands exactly timeout+1 edges after that write, so the bench counts falling edges from the write to sample the drop and the re-raise. Terminal error states are sampled after a margin well past four full attempts.

// File: rtl/usb_role_pkg.sv
package usb_role_pkg;
  localparam int ADDR_MODE = 0;
  localparam int ADDR_PWR  = 4;
  localparam int ADDR_TMO  = 8;
  localparam int BIT_OVR_SEL = 7;
  localparam int BIT_OVR_ID  = 8;
  localparam int BIT_PULL    = 6;
  localparam int BIT_SESS    = 0;
  localparam int RETRY_MAX = 3;
  localparam int RETRY_W   = 2;

  typedef enum logic [2:0] {
    HS_IDLE = 3'd0,
    HS_WAIT = 3'd1,
    HS_OFF  = 3'd2,
    HS_UP   = 3'd3,
    HS_FAIL = 3'd4
  } host_st_e;
endpackage

// File: rtl/usb_role_regs.sv
module usb_role_regs
  import usb_role_pkg::*;
#(
  parameter int AW = 4,
  parameter int TW = 16,
  parameter int TO_RST = 65535
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          ovr_sel,
  output logic          ovr_id,
  output logic          pull_req,
  output logic          sess_act,
  output logic          start_pls,
  output logic [TW-1:0] timeout
);
  localparam logic [AW-1:0] A_MODE = AW'(ADDR_MODE);
  localparam logic [AW-1:0] A_PWR  = AW'(ADDR_PWR);
  localparam logic [AW-1:0] A_TMO  = AW'(ADDR_TMO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_sel  <= 1'b0;
      ovr_id   <= 1'b0;
      pull_req <= 1'b0;
      sess_act <= 1'b0;
      timeout  <= TW'(TO_RST);
    end else if (wr) begin
      case (addr)
        A_MODE: begin
          ovr_sel <= wdata[BIT_OVR_SEL];
          ovr_id  <= wdata[BIT_OVR_ID];
        end
        A_PWR: begin
          pull_req <= wdata[BIT_PULL];
          sess_act <= wdata[BIT_SESS];
        end
        A_TMO: timeout <= wdata[TW-1:0];
        default: ;
      endcase
    end
  end

  assign start_pls = wr && (addr == A_PWR) && wdata[BIT_SESS];

  always_comb begin
    rdata = '0;
    case (addr)
      A_MODE: begin
        rdata[BIT_OVR_SEL] = ovr_sel;
        rdata[BIT_OVR_ID]  = ovr_id;
      end
      A_PWR: begin
        rdata[BIT_PULL] = pull_req;
        rdata[BIT_SESS] = sess_act;
      end
      A_TMO: rdata[TW-1:0] = timeout;
      default: ;
    endcase
  end
endmodule

// File: rtl/usb_role_arb.sv
module usb_role_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic phy_id,
  input  logic vbus_valid,
  input  logic ovr_sel,
  input  logic ovr_id,
  input  logic sess_act,
  input  logic pull_req,
  output logic ctl_id,
  output logic role_dev,
  output logic role_chg,
  output logic dp_pullup
);
  logic eff_id;
  logic next_dev;

  assign eff_id   = ovr_sel ? ovr_id : phy_id;
  assign ctl_id   = eff_id;
  // VBUS already present means another host supplies it: stay a peripheral
  assign next_dev = eff_id | vbus_valid;
  assign role_chg = !sess_act && (next_dev != role_dev);

  always_ff @(posedge clk) begin
    if (!rst_n)         role_dev <= 1'b1;
    else if (!sess_act) role_dev <= next_dev;
  end

  assign dp_pullup = pull_req & role_dev;
endmodule

// File: rtl/usb_role_vbus_fsm.sv
module usb_role_vbus_fsm
  import usb_role_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sess,
  input  logic               clr,
  input  logic               vbus_valid,
  input  logic [TW-1:0]      timeout,
  output logic               vbus_drive,
  output logic               vbus_err,
  output logic [RETRY_W-1:0] retry_cnt
);
  localparam logic [RETRY_W-1:0] RMAX = RETRY_W'(RETRY_MAX);

  host_st_e      st;
  logic [TW-1:0] cnt;
  logic          fault;

  assign fault = ((st == HS_WAIT) && !vbus_valid && (cnt == timeout - TW'(1)))
              || ((st == HS_UP) && !vbus_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= HS_IDLE;
      cnt       <= '0;
      vbus_err  <= 1'b0;
      retry_cnt <= '0;
    end else if (clr) begin
      st        <= HS_IDLE;
      cnt       <= '0;
      vbus_err  <= 1'b0;
      retry_cnt <= '0;
    end else if (!host_sess) begin
      st  <= HS_IDLE;
      cnt <= '0;
    end else if (fault) begin
      cnt <= '0;
      if (retry_cnt == RMAX) begin
        vbus_err <= 1'b1;
        st       <= HS_FAIL;
      end else begin
        retry_cnt <= retry_cnt + RETRY_W'(1);
        st        <= HS_OFF;
      end
    end else begin
      case (st)
        HS_IDLE, HS_OFF: begin
          st  <= HS_WAIT;
          cnt <= '0;
        end
        HS_WAIT: begin
          if (vbus_valid) st <= HS_UP;
          cnt <= cnt + TW'(1);
        end
        default: ;
      endcase
    end
  end

  assign vbus_drive = (st == HS_WAIT) || (st == HS_UP);
endmodule

// File: rtl/usb_role_select.sv
module usb_role_select
  import usb_role_pkg::*;
#(
  parameter int AW = 4,
  parameter int TW = 16,
  parameter int TO_RST = 65535
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               phy_id,
  input  logic               phy_vbus_valid,
  output logic               ctl_id,
  output logic               role_dev,
  output logic               vbus_drive,
  output logic               vbus_err,
  output logic [RETRY_W-1:0] retry_cnt,
  output logic               dp_pullup
);
  logic          ovr_sel, ovr_id, pull_req, sess_act, start_pls, role_chg;
  logic [TW-1:0] timeout;

  usb_role_regs #(.AW(AW), .TW(TW), .TO_RST(TO_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .ovr_sel(ovr_sel),
    .ovr_id(ovr_id), .pull_req(pull_req), .sess_act(sess_act),
    .start_pls(start_pls), .timeout(timeout)
  );

  usb_role_arb u_arb (
    .clk(clk), .rst_n(rst_n), .phy_id(phy_id), .vbus_valid(phy_vbus_valid),
    .ovr_sel(ovr_sel), .ovr_id(ovr_id), .sess_act(sess_act),
    .pull_req(pull_req), .ctl_id(ctl_id), .role_dev(role_dev),
    .role_chg(role_chg), .dp_pullup(dp_pullup)
  );

  usb_role_vbus_fsm #(.TW(TW)) u_vbus (
    .clk(clk), .rst_n(rst_n), .host_sess(sess_act && !role_dev),
    .clr(start_pls || role_chg), .vbus_valid(phy_vbus_valid),
    .timeout(timeout), .vbus_drive(vbus_drive), .vbus_err(vbus_err),
    .retry_cnt(retry_cnt)
  );
endmodule

// File: rtl/usb_role_chk.sv
module usb_role_chk
  import usb_role_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               phy_id,
  input logic               ovr_sel,
  input logic               sess_act,
  input logic               ctl_id,
  input logic               role_dev,
  input logic               vbus_drive,
  input logic               vbus_err,
  input logic [RETRY_W-1:0] retry_cnt,
  input logic               dp_pullup
);
  assert_id_follows_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_sel |-> (ctl_id == phy_id));

  assert_role_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_act && $past(sess_act)) |-> $stable(role_dev));

  assert_drive_host_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vbus_drive |-> !role_dev);

  assert_err_after_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vbus_err |-> (retry_cnt == RETRY_W'(RETRY_MAX) && !vbus_drive));

  assert_retry_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_cnt != $past(retry_cnt)) |->
      (retry_cnt == $past(retry_cnt) + RETRY_W'(1) || retry_cnt == '0));

  assert_pullup_dev_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dp_pullup |-> role_dev);
endmodule

bind usb_role_select usb_role_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phy_id(phy_id), .ovr_sel(ovr_sel),
  .sess_act(sess_act), .ctl_id(ctl_id), .role_dev(role_dev),
  .vbus_drive(vbus_drive), .vbus_err(vbus_err), .retry_cnt(retry_cnt),
  .dp_pullup(dp_pullup)
);

// File: tb/usb_role_select_tb.sv
module usb_role_select_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        phy_id, phy_vbus_valid;
  logic        ctl_id, role_dev, vbus_drive, vbus_err, dp_pullup;
  logic [1:0]  retry_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_role_select u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .phy_id(phy_id),
    .phy_vbus_valid(phy_vbus_valid), .ctl_id(ctl_id), .role_dev(role_dev),
    .vbus_drive(vbus_drive), .vbus_err(vbus_err), .retry_cnt(retry_cnt),
    .dp_pullup(dp_pullup)
  );

  // {mode[8:0], phy_id, vbus_valid, exp_ctl_id, exp_role_dev}
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    {9'h000, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 pin low -> host
    {9'h000, 1'b1, 1'b0, 1'b1, 1'b1},  // R4 pin floating -> device
    {9'h100, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 bit 8 alone ignored
    {9'h100, 1'b1, 1'b0, 1'b1, 1'b1},  // R2
    {9'h080, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 forced host
    {9'h180, 1'b0, 1'b0, 1'b1, 1'b1},  // R3 forced device
    {9'h080, 1'b0, 1'b1, 1'b0, 1'b1},  // R5 vbus present
    {9'h000, 1'b0, 1'b1, 1'b0, 1'b1}   // R5
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    phy_id = 1'b0; phy_vbus_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 role follows pin", {31'd0, role_dev}, 32'd0);
    check("R1 drive", {31'd0, vbus_drive}, 32'd0);
    check("R1 err", {31'd0, vbus_err}, 32'd0);
    check("R1 retry", {30'd0, retry_cnt}, 32'd0);
    check("R1 pullup", {31'd0, dp_pullup}, 32'd0);
    rd(4'h0, 32'h0, "R1 mode reads 0");
    rd(4'h4, 32'h0, "R1 power reads 0");
    rd(4'h8, 32'hFFFF, "R1 timeout reset");

    // table walk
    for (int i = 0; i < NV; i++) begin
      phy_id = VEC[i][3]; phy_vbus_valid = VEC[i][2];
      wr(4'h0, {23'd0, VEC[i][12:4]});
      @(negedge clk);
      check($sformatf("R2/R3 ctl_id vec%0d", i), {31'd0, ctl_id}, {31'd0, VEC[i][1]});
      check($sformatf("R4/R5 role vec%0d", i), {31'd0, role_dev}, {31'd0, VEC[i][0]});
    end

    wr(4'h8, T);
    rd(4'h8, T, "R11 timeout readback");

    // R6 role held during session
    phy_vbus_valid = 1'b0; phy_id = 1'b1;
    wr(4'h0, 32'h080);
    @(negedge clk);
    wr(4'h4, 32'h1);
    wr(4'h0, 32'h180);
    repeat (3) @(negedge clk);
    check("R6 role held in session", {31'd0, role_dev}, 32'd0);
    check("R3 ctl_id after override", {31'd0, ctl_id}, 32'd1);
    wr(4'h4, 32'h0);
    @(negedge clk);
    check("R6 role after session end", {31'd0, role_dev}, 32'd1);
    check("R9 retry cleared on role change", {30'd0, retry_cnt}, 32'd0);

    // R7 host supply comes up
    wr(4'h0, 32'h080);
    @(negedge clk);
    wr(4'h4, 32'h1);
    @(negedge clk);
    check("R7 drive after start", {31'd0, vbus_drive}, 32'd1);
    phy_vbus_valid = 1'b1;
    repeat (3 * T) @(negedge clk);
    check("R7 drive held", {31'd0, vbus_drive}, 32'd1);
    check("R7 no retry", {30'd0, retry_cnt}, 32'd0);
    check("R7 no err", {31'd0, vbus_err}, 32'd0);
    wr(4'h4, 32'h0);
    phy_vbus_valid = 1'b0;
    @(negedge clk);
    check("R7 drive off at end", {31'd0, vbus_drive}, 32'd0);

    // R8 timeouts and retries
    @(negedge clk);
    wr(4'h4, 32'h1);
    repeat (T + 1) @(negedge clk);
    check("R8 drive dropped", {31'd0, vbus_drive}, 32'd0);
    check("R8 retry 1", {30'd0, retry_cnt}, 32'd1);
    @(negedge clk);
    check("R8 drive retried", {31'd0, vbus_drive}, 32'd1);
    repeat (4 * (T + 1) + 10) @(negedge clk);
    check("R8 err latched", {31'd0, vbus_err}, 32'd1);
    check("R8 retry at max", {30'd0, retry_cnt}, 32'd3);
    check("R8 drive off", {31'd0, vbus_drive}, 32'd0);

    // R9 clear via session-start write
    wr(4'h4, 32'h1);
    @(negedge clk);
    check("R9 err cleared by start", {31'd0, vbus_err}, 32'd0);
    check("R9 retry cleared by start", {30'd0, retry_cnt}, 32'd0);
    repeat (5 * (T + 1) + 10) @(negedge clk);
    wr(4'h4, 32'h0);
    @(negedge clk);
    check("R9 err kept after end", {31'd0, vbus_err}, 32'd1);
    wr(4'h0, 32'h180);
    @(negedge clk);
    check("R9 err cleared by role change", {31'd0, vbus_err}, 32'd0);

    // R10 pull-up
    wr(4'h4, 32'h40);
    @(negedge clk);
    check("R10 pullup in device role", {31'd0, dp_pullup}, 32'd1);
    wr(4'h0, 32'h080);
    @(negedge clk);
    check("R10 pullup off in host role", {31'd0, dp_pullup}, 32'd0);
    rd(4'h4, 32'h40, "R10 power readback");

    // R11 reserved bits
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 32'h180, "R11 mode reserved bits");
    wr(4'h4, 32'hFFFF_FFBE);
    rd(4'h4, 32'h0, "R11 power reserved bits");
    wr(4'h8, 32'hABCD_1234);
    rd(4'h8, 32'h1234, "R11 timeout width");
    rd(4'hC, 32'h0, "R11 unmapped address");

    finish_run();
  end
endmodule